// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 96 level-sensitive peripheral request lines into three banks of 32. Each bank has an enable mask and a routing bit per source. The routing bit sends an enabled source either to the normal interrupt line or to the fast interrupt line. Software sees each bank through four views: raw levels, enabled normal requests, enabled fast requests, and the mask and routing registers themselves.

One priority slot exists for each source. Slot 0 has the highest priority. Each slot carries a valid bit and the number of the source it stands for. A read-only winner register reports the lowest-numbered valid slot whose source is an enabled, normal-routed request, along with a found flag. The winner is recomputed from the current state every cycle.

A control bit chooses which requests can wake the core from idle: any raw request, or only enabled requests. Software reaches all state over a simple synchronous bus. A read returns its data one cycle after the read strobe.

Top module: `prio_intc`

## Requirements
- R1: After reset, all mask bits, routing bits, the control bit and every priority slot read as zero, and `irq_o`, `fiq_o` and `wake_o` are low while no source is raised.
- R2: The mask registers sit at 0x004, 0x0A0 and 0x134 and the routing registers at 0x008, 0x0A4 and 0x138, for banks 0, 1 and 2. They hold and read back written values, and a mask bit of 1 enables its source.
- R3: The normal-pending view of each bank (0x000, 0x09C, 0x130) reads source level AND mask AND NOT routing. `irq_o` is the OR of these bits across all banks.
- R4: The fast-pending view of each bank (0x00C, 0x0A8, 0x13C) reads source level AND mask AND routing. `fiq_o` is the OR of these bits across all banks.
- R5: The raw view of each bank (0x010, 0x0AC, 0x140) reads the source levels whatever the mask and routing bits are.
- R6: Priority slot i is at 0x01C+4i for i<32, at 0x0B0+4(i-32) for 32≤i<64, and at 0x144+4(i-64) above that. Bit 31 is valid and bits 6:0 hold the source number. Both read back as written.
- R7: The winner register at 0x018 has bit 31 set when a valid slot names an enabled, normal-routed pending source. Bits 30:16 then hold the source number of the lowest-numbered such slot.
- R8: Invalid slots and slots naming a fast-routed or non-pending source never win. With no winner, 0x018 reads zero.
- R9: Control bit 0 is at 0x014. When it is 1, `wake_o` follows only enabled pending sources. When it is 0, `wake_o` follows any raw pending source.
- R10: Reads of unmapped offsets return zero. Writes to the pending views and the winner register change no state.
- R11: Read data appears on `rdata` in the cycle after `rd_en`. When a read and a write hit the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 96 | Peripheral request levels |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 9 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake-from-idle request |

## Verification
The two functions that can collide are a register read and a register write to the same offset in the same cycle. This bench raises both strobes together on a mask register. It expects the old mask value on `rdata` in the next cycle, and then expects a fresh read to show the new value. The winner register is read after the changed mask has removed the previous winner's enable, so the effect of the write on arbitration is checked in the cycle that follows it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam int BANK_W = 32;

  // per-bank view offsets relative to the bank base
  localparam logic [ADDR_W-1:0] OFF_IRQ  = 9'h000;
  localparam logic [ADDR_W-1:0] OFF_MASK = 9'h004;
  localparam logic [ADDR_W-1:0] OFF_LVL  = 9'h008;
  localparam logic [ADDR_W-1:0] OFF_FIQ  = 9'h00C;
  localparam logic [ADDR_W-1:0] OFF_RAW  = 9'h010;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 9'h014;
  localparam logic [ADDR_W-1:0] ADR_WIN  = 9'h018;

  typedef struct packed {
    logic              hit;
    logic [DATA_W-1:0] data;
  } rd_resp_t;

  function automatic logic [ADDR_W-1:0] bank_base(input int b);
    case (b)
      0:       return 9'h000;
      1:       return 9'h09C;
      default: return 9'h130;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input int s);
    int a;
    if (s < 32)      a = 'h01C + 4 * s;
    else if (s < 64) a = 'h0B0 + 4 * (s - 32);
    else             a = 'h144 + 4 * (s - 64);
    return a[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int BANK_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BANK_W-1:0] src,
  output logic [BANK_W-1:0] irq_pend,
  output logic [BANK_W-1:0] fiq_pend,
  output logic [BANK_W-1:0] unmasked,
  output rd_resp_t          rsp
);
  localparam logic [ADDR_W-1:0] BASE = bank_base(BANK_IDX);

  logic [BANK_W-1:0] mask_q, lvl_q;
  logic              mask_we, lvl_we;

  always_comb begin
    mask_we = wr_en && (addr == BASE + OFF_MASK);
    lvl_we  = wr_en && (addr == BASE + OFF_LVL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (mask_we) mask_q <= wdata[BANK_W-1:0];
      if (lvl_we)  lvl_q  <= wdata[BANK_W-1:0];
    end
  end

  always_comb begin
    unmasked = src & mask_q;
    irq_pend = unmasked & ~lvl_q;
    fiq_pend = unmasked & lvl_q;
  end

  always_comb begin
    rsp = '0;
    if (addr == BASE + OFF_IRQ) begin
      rsp.hit = 1'b1; rsp.data = irq_pend;
    end else if (addr == BASE + OFF_MASK) begin
      rsp.hit = 1'b1; rsp.data = mask_q;
    end else if (addr == BASE + OFF_LVL) begin
      rsp.hit = 1'b1; rsp.data = lvl_q;
    end else if (addr == BASE + OFF_FIQ) begin
      rsp.hit = 1'b1; rsp.data = fiq_pend;
    end else if (addr == BASE + OFF_RAW) begin
      rsp.hit = 1'b1; rsp.data = src;
    end
  end

  // R2: a mask write is visible the following cycle
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata[BANK_W-1:0])));
  // R2: a routing write is visible the following cycle
  a_r2_lvl_write: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_we |=> (lvl_q == $past(wdata[BANK_W-1:0])));
  // R4: a source is never on both lines
  a_r4_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend & fiq_pend) == '0);
endmodule

// File: rtl/intc_prio.sv
module intc_prio
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int ID_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_vld,
  input  logic [ID_W-1:0]    wr_id,
  input  logic [NUM_SRC-1:0] irq_pend,
  output logic               win_vld,
  output logic [ID_W-1:0]    win_id,
  output rd_resp_t           rsp
);
  localparam int NUM_SLOT = NUM_SRC;
  localparam int PAD      = 1 << ID_W;

  logic [NUM_SLOT-1:0]           vld_q;
  logic [NUM_SLOT-1:0][ID_W-1:0] id_q;
  logic [NUM_SLOT-1:0]           slot_hit, slot_we;
  logic [PAD-1:0]                pend_pad;

  always_comb begin
    for (int s = 0; s < NUM_SLOT; s++) begin
      slot_hit[s] = (addr == slot_addr(s));
      slot_we[s]  = wr_en && slot_hit[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      id_q  <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOT; s++) begin
        if (slot_we[s]) begin
          vld_q[s] <= wr_vld;
          id_q[s]  <= wr_id;
        end
      end
    end
  end

  always_comb begin
    rsp = '0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (slot_hit[s]) begin
        rsp.hit             = 1'b1;
        rsp.data[DATA_W-1]  = vld_q[s];
        rsp.data[ID_W-1:0]  = id_q[s];
      end
    end
  end

  // arbitration: walk from the lowest priority up so slot 0 wins last
  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_SRC-1:0] = irq_pend;
    win_vld = 1'b0;
    win_id  = '0;
    for (int s = NUM_SLOT - 1; s >= 0; s--) begin
      if (vld_q[s] && pend_pad[id_q[s]]) begin
        win_vld = 1'b1;
        win_id  = id_q[s];
      end
    end
  end

  // R7: the reported winner is a pending normal request
  a_r7_win_pending: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> pend_pad[win_id]);
  // R8: no valid slot means no winner
  a_r8_no_slot_no_win: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q == '0) |-> !win_vld);
  // R8: no pending request means no winner
  a_r8_no_pend_no_win: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend == '0) |-> !win_vld);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  localparam int NBANK   = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int SRC_PAD = NBANK * BANK_W;
  localparam int ID_W    = $clog2(NUM_SRC);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SRC_PAD-1:0] src_pad, irq_all, fiq_all, unm_all;
  rd_resp_t           bank_rsp [NBANK];
  rd_resp_t           prio_rsp;
  logic               win_vld;
  logic [ID_W-1:0]    win_id;

  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src_i;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    intc_bank #(.BANK_IDX(b)) u_bank (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .src      (src_pad[b*BANK_W +: BANK_W]),
      .irq_pend (irq_all[b*BANK_W +: BANK_W]),
      .fiq_pend (fiq_all[b*BANK_W +: BANK_W]),
      .unmasked (unm_all[b*BANK_W +: BANK_W]),
      .rsp      (bank_rsp[b])
    );
  end

  intc_prio #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_prio (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_vld   (wdata[DATA_W-1]),
    .wr_id    (wdata[ID_W-1:0]),
    .irq_pend (irq_all[NUM_SRC-1:0]),
    .win_vld  (win_vld),
    .win_id   (win_id),
    .rsp      (prio_rsp)
  );

  // wake control
  logic ctrl_q, ctrl_we;
  assign ctrl_we = wr_en && (addr == ADR_CTRL);
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= 1'b0;
    else if (ctrl_we) ctrl_q <= wdata[0];
  end

  // read mux and return register
  logic [14:0]       win_fld;
  logic [DATA_W-1:0] rd_d, rdata_q;
  always_comb begin
    win_fld = '0;
    win_fld[ID_W-1:0] = win_id;
    rd_d = '0;
    for (int b = 0; b < NBANK; b++)
      if (bank_rsp[b].hit) rd_d = rd_d | bank_rsp[b].data;
    if (prio_rsp.hit) rd_d = rd_d | prio_rsp.data;
    if (addr == ADR_CTRL) rd_d = {{(DATA_W-1){1'b0}}, ctrl_q};
    if (addr == ADR_WIN)  rd_d = {win_vld, win_fld, 16'h0000};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end
  assign rdata = rdata_q;

  always_comb begin
    irq_o  = |irq_all;
    fiq_o  = |fiq_all;
    wake_o = ctrl_q ? (|unm_all) : (|src_pad);
  end

  // R7: a winner always implies the normal line is up
  a_r7_win_irq: assert property (@(posedge clk) disable iff (!rst_int_n)
    win_vld |-> irq_o);
  // R9: in filtered mode, wake only with an enabled request
  a_r9_wake_filtered: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_q && wake_o) |-> (irq_o || fiq_o));
  // R9: any line up implies wake in either mode
  a_r9_wake_cover: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_o || fiq_o) |-> wake_o);
  // R11: read data only moves after a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o, wake_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
  );

  // op: 0 write, 1 read and compare, 2 set source word of bank (addr = bank)
  localparam int NV = 29;
  localparam logic [46:0] VEC [NV] = '{
    {2'd0, 4'd2, 9'h004, 32'h0000_00F0},  // R2 bank0 mask
    {2'd1, 4'd2, 9'h004, 32'h0000_00F0},  // R2 readback
    {2'd0, 4'd4, 9'h008, 32'h0000_0080},  // R4 source 7 to fast line
    {2'd2, 4'd3, 9'h000, 32'h0000_00A5},  // R3 sources 0,2,5,7
    {2'd1, 4'd3, 9'h000, 32'h0000_0020},  // R3 normal view
    {2'd1, 4'd4, 9'h00C, 32'h0000_0080},  // R4 fast view
    {2'd1, 4'd5, 9'h010, 32'h0000_00A5},  // R5 raw view
    {2'd1, 4'd8, 9'h018, 32'h0000_0000},  // R8 no valid slot
    {2'd0, 4'd6, 9'h01C, 32'h8000_0007},  // R6 slot0 -> 7 (fast routed)
    {2'd0, 4'd6, 9'h020, 32'h8000_0005},  // R6 slot1 -> 5
    {2'd1, 4'd7, 9'h018, 32'h8005_0000},  // R7 slot0 skipped, 5 wins
    {2'd1, 4'd6, 9'h01C, 32'h8000_0007},  // R6 slot readback
    {2'd0, 4'd2, 9'h0A0, 32'h0000_0002},  // R2 bank1 mask, source 33
    {2'd2, 4'd3, 9'h001, 32'h0000_0002},
    {2'd1, 4'd3, 9'h09C, 32'h0000_0002},  // R3 bank1 normal view
    {2'd0, 4'd6, 9'h0D0, 32'h8000_0021},  // R6 slot40 -> 33
    {2'd1, 4'd7, 9'h018, 32'h8005_0000},  // R7 slot1 still ahead
    {2'd0, 4'd7, 9'h01C, 32'h8000_0021},  // slot0 -> 33
    {2'd1, 4'd7, 9'h018, 32'h8021_0000},  // R7 slot0 now wins
    {2'd0, 4'd2, 9'h134, 32'h8000_0000},  // R2 bank2 mask, source 95
    {2'd2, 4'd3, 9'h002, 32'h8000_0000},
    {2'd0, 4'd6, 9'h1C0, 32'h8000_005F},  // R6 slot95 -> 95
    {2'd1, 4'd6, 9'h1C0, 32'h8000_005F},
    {2'd0, 4'd8, 9'h01C, 32'h0000_0000},  // R8 invalidate slot0
    {2'd0, 4'd8, 9'h020, 32'h0000_0000},  // R8 invalidate slot1
    {2'd1, 4'd8, 9'h018, 32'h8021_0000},  // R8 slot40 is lowest valid
    {2'd1, 4'd3, 9'h130, 32'h8000_0000},  // R3 bank2 normal view
    {2'd1, 4'd5, 9'h140, 32'h8000_0000},  // R5 bank2 raw view
    {2'd1, 4'd2, 9'h138, 32'h0000_0000}   // R2 bank2 routing
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    do_read(a, d);
    chk(req, d, exp);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
    chk("R1 fiq_o", {31'd0, fiq_o}, 32'd0);
    chk("R1 wake_o", {31'd0, wake_o}, 32'd0);
    rd_chk("R1 mask", 9'h004, 32'd0);
    rd_chk("R1 routing", 9'h0A4, 32'd0);
    rd_chk("R1 control", 9'h014, 32'd0);
    rd_chk("R1 winner", 9'h018, 32'd0);
    rd_chk("R1 slot", 9'h0D0, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      case (v[46:45])
        2'd0: do_write(v[40:32], v[31:0]);
        2'd1: rd_chk($sformatf("R%0d vector %0d", v[44:41], i), v[40:32], v[31:0]);
        default: begin
          @(negedge clk);
          src_i[int'(v[40:32])*32 +: 32] = v[31:0];
        end
      endcase
    end

    // R3 R4 output lines: source 5 normal, source 7 fast
    @(negedge clk);
    chk("R3 irq_o", {31'd0, irq_o}, 32'd1);
    chk("R4 fiq_o", {31'd0, fiq_o}, 32'd1);

    // R9 wake: only a disabled source raised
    src_i = 96'h1;
    @(negedge clk);
    chk("R3 irq_o low", {31'd0, irq_o}, 32'd0);
    chk("R9 raw wake", {31'd0, wake_o}, 32'd1);
    do_write(9'h014, 32'h1);
    @(negedge clk);
    chk("R9 filtered wake", {31'd0, wake_o}, 32'd0);
    rd_chk("R9 control", 9'h014, 32'h1);
    src_i = 96'h20;
    @(negedge clk);
    chk("R9 enabled wake", {31'd0, wake_o}, 32'd1);

    // R10 unmapped and read-only
    rd_chk("R10 unmapped", 9'h1C4, 32'd0);
    rd_chk("R10 unmapped", 9'h1F0, 32'd0);
    do_write(9'h024, 32'h8000_0005);
    rd_chk("R7 slot2 winner", 9'h018, 32'h8005_0000);
    do_write(9'h018, 32'hFFFF_FFFF);
    do_write(9'h000, 32'hFFFF_FFFF);
    do_write(9'h010, 32'hFFFF_FFFF);
    rd_chk("R10 mask kept", 9'h004, 32'h0000_00F0);
    rd_chk("R10 routing kept", 9'h008, 32'h0000_0080);
    rd_chk("R10 winner kept", 9'h018, 32'h8005_0000);

    // R11 read and write to one register in the same cycle
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 9'h004; wdata = 32'h0000_000F;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R11 old value", rdata, 32'h0000_00F0);
    rd_chk("R11 new value", 9'h004, 32'h0000_000F);
    rd_chk("R8 winner gone", 9'h018, 32'd0);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    src_i = '0;
    rd_chk("R1 mask after reset", 9'h004, 32'd0);
    rd_chk("R1 slot after reset", 9'h0D0, 32'd0);

    summary();
  end
endmodule